// File: doc/BRIEF.md
# Operand Effective-Address Unit

This unit turns an addressing-mode code into the 16-bit effective address of an instruction operand, following the wrap-around rules of a classic 8-bit processor. The request supplies the mode, the program counter (already pointing at the first operand byte), and the X and Y index registers. The unit then walks through the memory reads the mode needs on a byte-wide synchronous read port and reports the result with a single-cycle completion pulse.

The mode, program counter and the selected index are captured on the cycle a request is accepted. The read port returns data in the cycle after an address is presented. The unit issues at most one read per cycle. Pointers held in memory are little-endian. Arithmetic on a zero-page pointer never leaves page zero, and arithmetic on a full address wraps modulo 65536. A code that names no operand mode is rejected with an error flag.

Top module: `opaddr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, done_o, err_o, mem_req_o and busy_o are all low.
- R2: Mode code 0 (immediate) raises done_o in the cycle after start_i is sampled, with addr_o equal to pc_i and no memory read.
- R3: Mode code 1 (zero page) reads once at pc_i in the first cycle after start and raises done_o in the third cycle, with addr_o equal to the fetched byte zero-extended.
- R4: Mode codes 2 and 3 (zero page plus X, plus Y) behave as R3, but addr_o is (byte + index) mod 256, so its upper byte is always zero.
- R5: Mode code 4 (absolute) reads pc_i in cycle 1 and (pc_i+1) mod 65536 in cycle 2, raises done_o in cycle 4, and returns {second byte, first byte}.
- R6: Mode codes 5 and 6 (absolute plus X, plus Y) behave as R5 and add the zero-extended index modulo 65536.
- R7: Mode code 7 (pre-indexed indirect) reads pc_i in cycle 1, forms p = (byte + X) mod 256, reads p in cycle 3 and (p+1) mod 256 in cycle 4, raises done_o in cycle 6, and returns {data at p+1, data at p}.
- R8: Mode code 8 (post-indexed indirect) reads pc_i in cycle 1, reads the byte b in cycle 3 and (b+1) mod 256 in cycle 4, raises done_o in cycle 6, and returns ({data at b+1, data at b} + Y) mod 65536.
- R9: Mode codes 9 to 15 raise err_o together with done_o in the cycle after start, with no memory read. err_o is never high without done_o.
- R10: done_o is a single-cycle pulse. busy_o is high from the first cycle after acceptance through the done cycle. A new request is accepted in the cycle after done_o.
- R11: start_i is ignored while busy_o is high. The request in flight completes with its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled while idle |
| mode_i | input | 4 | Addressing-mode code |
| pc_i | input | 16 | Address of the first operand byte |
| x_i | input | 8 | X index register |
| y_i | input | 8 | Y index register |
| mem_req_o | output | 1 | Read request this cycle |
| mem_addr_o | output | 16 | Read address |
| mem_data_i | input | 8 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Result valid, one-cycle pulse |
| err_o | output | 1 | Illegal mode, with done_o |
| addr_o | output | 16 | Effective address |

## Verification
Every mode runs against a behavioural reference that predicts, cycle by cycle, the read address, busy, done and the final address. Typical operands tell the modes' read sequences apart: how many reads each mode issues and which cycles they fall in. Wrap cases separate modulo-256 from modulo-65536 arithmetic: a zero-page index carry, a pointer at 0xFF, an absolute base near 0xFFFF, and a program counter of 0xFFFF. Illegal codes, back-to-back requests and strobes raised mid-request check the rejection path and that the latched inputs hold.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [2:0] {K_IMM, K_ZP, K_ABS, K_INDX, K_INDY, K_ILL} kind_e;
  typedef enum logic [1:0] {IX_NONE, IX_X, IX_Y} idx_e;

  typedef struct packed {
    kind_e kind;
    idx_e  idx;
  } mode_dec_t;

  typedef enum logic [2:0] {
    S_IDLE, S_OP, S_HI, S_WAIT, S_PLO, S_PHI, S_CAP, S_DONE
  } st_e;
endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_dec_t         dec_o
);
  always_comb begin
    unique case (mode_i)
      4'd0:    dec_o = '{kind: K_IMM,  idx: IX_NONE};
      4'd1:    dec_o = '{kind: K_ZP,   idx: IX_NONE};
      4'd2:    dec_o = '{kind: K_ZP,   idx: IX_X};
      4'd3:    dec_o = '{kind: K_ZP,   idx: IX_Y};
      4'd4:    dec_o = '{kind: K_ABS,  idx: IX_NONE};
      4'd5:    dec_o = '{kind: K_ABS,  idx: IX_X};
      4'd6:    dec_o = '{kind: K_ABS,  idx: IX_Y};
      4'd7:    dec_o = '{kind: K_INDX, idx: IX_X};
      4'd8:    dec_o = '{kind: K_INDY, idx: IX_Y};
      default: dec_o = '{kind: K_ILL,  idx: IX_NONE};
    endcase
  end
endmodule

// File: rtl/agu_fsm.sv
module agu_fsm
  import agu_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  kind_e kind_i,
  output logic  load_o,
  output kind_e kind_o,
  output st_e   state_o,
  output logic  busy_o,
  output logic  done_o,
  output logic  err_o
);
  st_e   state_q, state_d;
  kind_e kind_q;

  assign load_o = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i)
                state_d = (kind_i == K_IMM || kind_i == K_ILL) ? S_DONE : S_OP;
      S_OP:   state_d = (kind_q == K_ABS) ? S_HI : S_WAIT;
      S_HI:   state_d = S_CAP;
      S_WAIT: state_d = (kind_q == K_ZP) ? S_DONE : S_PLO;
      S_PLO:  state_d = S_PHI;
      S_PHI:  state_d = S_CAP;
      S_CAP:  state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_IMM;
    end else begin
      state_q <= state_d;
      if (load_o) kind_q <= kind_i;
    end
  end

  assign kind_o  = kind_q;
  assign state_o = state_q;
  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_DONE);
  assign err_o   = done_o && (kind_q == K_ILL);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  a_r2_imm_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && kind_i == K_IMM) |=> (done_o && !err_o));
  a_r11_kind_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(kind_q));
endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  kind_e             load_kind_i,
  input  idx_e              idx_sel_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  kind_e             kind_i,
  input  st_e               state_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] pc_q, res_q;
  logic [DATA_W-1:0] idx_q, op_q, lo_q;
  logic [DATA_W-1:0] ptr, zsum, post;
  logic [ADDR_W-1:0] full;

  // pointer stays in page zero
  assign ptr  = (kind_i == K_INDX) ? DATA_W'(op_q + idx_q) : op_q;
  assign zsum = DATA_W'(mem_data_i + idx_q);
  assign post = (kind_i == K_INDX) ? '0 : idx_q;
  assign full = ADDR_W'({mem_data_i, lo_q} + {{DATA_W{1'b0}}, post});

  always_comb begin
    mem_req_o  = 1'b1;
    unique case (state_i)
      S_OP:    mem_addr_o = pc_q;
      S_HI:    mem_addr_o = ADDR_W'(pc_q + ADDR_W'(1));
      S_PLO:   mem_addr_o = {{DATA_W{1'b0}}, ptr};
      S_PHI:   mem_addr_o = {{DATA_W{1'b0}}, DATA_W'(ptr + DATA_W'(1))};
      default: begin
        mem_req_o  = 1'b0;
        mem_addr_o = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      idx_q <= '0;
      op_q  <= '0;
      lo_q  <= '0;
      res_q <= '0;
    end else begin
      if (load_i) begin
        pc_q  <= pc_i;
        idx_q <= (idx_sel_i == IX_X) ? x_i : (idx_sel_i == IX_Y) ? y_i : '0;
        res_q <= (load_kind_i == K_IMM) ? pc_i : '0;
      end
      unique case (state_i)
        S_WAIT: begin
          op_q <= mem_data_i;
          if (kind_i == K_ZP) res_q <= {{DATA_W{1'b0}}, zsum};
        end
        S_HI, S_PHI: lo_q <= mem_data_i;
        S_CAP:       res_q <= full;
        default: ;
      endcase
    end
  end

  assign addr_o = res_q;

  a_r4_zp_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_DONE && kind_i == K_ZP) |-> (addr_o[ADDR_W-1:DATA_W] == '0));
  a_r5_hi_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_HI) |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + ADDR_W'(1))));
  a_r7_ptr_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_PHI) |->
      (mem_addr_o[DATA_W-1:0] == DATA_W'($past(mem_addr_o[DATA_W-1:0]) + DATA_W'(1))));
  a_r9_no_read_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_IDLE || state_i == S_DONE) |-> !mem_req_o);
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import agu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o
);
  mode_dec_t dec;
  logic      load;
  kind_e     kind_q;
  st_e       state;

  agu_decode u_dec (.mode_i(mode_i), .dec_o(dec));

  agu_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .kind_i(dec.kind),
    .load_o(load), .kind_o(kind_q), .state_o(state),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  agu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_kind_i(dec.kind),
    .idx_sel_i(dec.idx), .pc_i(pc_i), .x_i(x_i), .y_i(y_i),
    .kind_i(kind_q), .state_i(state), .mem_data_i(mem_data_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .addr_o(addr_o)
  );

  a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!done_o && !mem_req_o));
endmodule

// File: tb/tb_opaddr_gen.sv
module tb_opaddr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  x = '0, y = '0;
  logic        mem_req, busy, done, err;
  logic [15:0] mem_addr, addr;
  logic [7:0]  mem_data = '0;

  int n_run = 0, n_fail = 0;
  logic [7:0] ovr [logic [15:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  opaddr_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .mode_i(mode), .pc_i(pc),
    .x_i(x), .y_i(y), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .busy_o(busy), .done_o(done), .err_o(err), .addr_o(addr)
  );

  function automatic logic [7:0] mem_f(logic [15:0] a);
    if (ovr.exists(a)) return ovr[a];
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_req) mem_data <= mem_f(mem_addr);

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called at a negedge with the unit idle
  task automatic run_case(logic [3:0] m, logic [15:0] p, logic [7:0] xv,
                          logic [7:0] yv, string req, bit inj);
    int lat; bit e_err; logic [15:0] res;
    bit er [8]; logic [15:0] ea [8];
    logic [7:0] op, q, lo, hi;
    for (int i = 0; i < 8; i++) begin er[i] = 0; ea[i] = '0; end
    op = mem_f(p); e_err = 0; res = '0;
    case (m)
      0: begin lat = 1; res = p; end
      1, 2, 3: begin
        lat = 3; er[1] = 1; ea[1] = p;
        res = {8'h00, 8'(op + (m == 2 ? xv : m == 3 ? yv : 8'h00))};
      end
      4, 5, 6: begin
        lat = 4; er[1] = 1; ea[1] = p; er[2] = 1; ea[2] = 16'(p + 1);
        res = 16'({mem_f(16'(p + 1)), op} + (m == 5 ? xv : m == 6 ? yv : 8'h00));
      end
      7, 8: begin
        q = (m == 7) ? 8'(op + xv) : op;
        lo = mem_f({8'h00, q}); hi = mem_f({8'h00, 8'(q + 1)});
        lat = 6; er[1] = 1; ea[1] = p; er[3] = 1; ea[3] = {8'h00, q};
        er[4] = 1; ea[4] = {8'h00, 8'(q + 1)};
        res = (m == 7) ? {hi, lo} : 16'({hi, lo} + yv);
      end
      default: begin lat = 1; e_err = 1; end
    endcase
    start = 1; mode = m; pc = p; x = xv; y = yv;
    for (int c = 1; c <= lat + 1; c++) begin
      @(negedge clk);
      start = 0;
      if (inj && c == 2) begin
        start = 1; mode = 4'd0; pc = ~p; x = ~xv; y = ~yv;
      end
      if (c <= lat) begin
        check(busy === 1'b1, "R10", $sformatf("busy m%0d c%0d", m, c), busy, 1);
        check(mem_req === er[c], req, $sformatf("req m%0d c%0d", m, c), mem_req, er[c]);
        if (er[c])
          check(mem_addr === ea[c], req, $sformatf("rd addr m%0d c%0d", m, c), mem_addr, ea[c]);
        check(done === (c == lat), req, $sformatf("done m%0d c%0d", m, c), done, c == lat);
      end else begin
        check(!done && !busy, "R10", $sformatf("idle after m%0d", m), {done, busy}, 0);
      end
      if (c == lat) begin
        check(err === e_err, e_err ? "R9" : req, $sformatf("err m%0d", m), err, e_err);
        if (!e_err) check(addr === res, req, $sformatf("addr m%0d", m), addr, res);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired: actual hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({done, err, mem_req, busy} === 4'b0, "R1", "outputs in reset", {done, err, mem_req, busy}, 0);
    rst_ni = 1;
    @(negedge clk);
    check({done, err, mem_req, busy} === 4'b0, "R1", "outputs after reset", {done, err, mem_req, busy}, 0);

    run_case(4'd0, 16'h1234, 8'h00, 8'h00, "R2", 0);
    run_case(4'd0, 16'hFFFF, 8'h11, 8'h22, "R2", 0);
    run_case(4'd1, 16'h8000, 8'h55, 8'h66, "R3", 0);
    run_case(4'd2, 16'h8010, 8'h05, 8'h00, "R4", 0);
    ovr[16'h9000] = 8'hF0;
    run_case(4'd2, 16'h9000, 8'h20, 8'h00, "R4", 0);   // wraps to 0x0010
    run_case(4'd3, 16'h9000, 8'h00, 8'h1F, "R4", 0);
    run_case(4'd4, 16'h8123, 8'h00, 8'h00, "R5", 0);
    run_case(4'd4, 16'hFFFF, 8'h00, 8'h00, "R5", 0);   // pc+1 wraps
    ovr[16'hA000] = 8'hF0; ovr[16'hA001] = 8'hFF;
    run_case(4'd5, 16'hA000, 8'h20, 8'h00, "R6", 0);   // 0xFFF0+0x20
    run_case(4'd6, 16'hA000, 8'h00, 8'h80, "R6", 0);
    ovr[16'hB000] = 8'hFB;
    run_case(4'd7, 16'hB000, 8'h04, 8'h00, "R7", 0);   // pointer at 0xFF
    run_case(4'd7, 16'h8040, 8'h10, 8'h00, "R7", 0);
    ovr[16'hB100] = 8'hFF; ovr[16'h00FF] = 8'hF8; ovr[16'h0000] = 8'hFF;
    run_case(4'd8, 16'hB100, 8'h00, 8'h10, "R8", 0);   // base 0xFF, sum wraps
    run_case(4'd8, 16'h8200, 8'h33, 8'h44, "R8", 0);
    run_case(4'd9, 16'h4000, 8'h00, 8'h00, "R9", 0);
    run_case(4'd15, 16'h4000, 8'h00, 8'h00, "R9", 0);
    run_case(4'd5, 16'hA000, 8'h01, 8'h00, "R11", 1);
    run_case(4'd8, 16'h8200, 8'h33, 8'h44, "R11", 1);
    run_case(4'd1, 16'h8300, 8'h00, 8'h00, "R11", 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule